// File: doc/BRIEF.md
# Stereo soft-mute attenuation ramp

The block sits in the sample path right after the serial audio receiver. It takes one stereo pair of 32-bit two's-complement samples per sample-valid strobe. It scales both channels by a gain that falls or rises by exactly 1 dB per sample period. When the attenuation reaches full silence, the analog-mute output goes high. Muting therefore happens in two stages: the digital level fades to zero first, and only then does the analog switch engage. Un-muting reverses the same path.

A mute request comes from either of two sources: the active-low soft-mute input, or a clock-error request from elsewhere in the chip. During a clock-error request the block stops using the incoming data. It keeps the last sample pair that arrived while no error was flagged, and fades that pair out instead. A separate zero-data detector counts consecutive pairs in which both channels are zero. After a long run of such pairs it raises analog mute on its own. The first nonzero sample on either channel releases it.

Top module: `soft_mute_ramp`

## Requirements
- R1: After reset, valid_o, left_o, right_o and amute_o are 0, and the attenuation level is 0 (unity gain).
- R2: The attenuation level L runs from 0 to 104, and each level has a gain code G(L).
  - G(0) = 65536.
  - For 1 ≤ L ≤ 103, G(L) = floor((G(L-1)·58409 + 32768) / 65536), which is 1 dB per step.
  - G(104) = 0.
  - Each output equals floor((x·G(L) + 32768) / 65536) clamped to the signed 32-bit range, where x is the selected input sample and L is the level after that sample's update.
- R3: While a mute is requested (soft_mute_ni low or clk_err_i high), each accepted sample raises L by one until L reaches 104. The n-th sample after the request uses level n.
- R4: While no mute is requested, each accepted sample lowers L by one until L reaches 0. A full ramp in either direction therefore takes 104 sample periods.
- R5: If the request reverses part-way through a ramp, L continues from its current value in the new direction, without a jump.
- R6: L changes only on cycles with valid_i high, and changes of the mute inputs between strobes have no effect. valid_o follows valid_i one clock later, and the output data is registered with that strobe.
- R7: amute_o is high whenever L is 104, and it rises together with the first all-zero output. While L is below 104, amute_o is high only because of the zero-data detector.
- R8: amute_o is high once 1024 consecutive accepted pairs have had both channels zero. It rises with the output of the 1024th such pair. A nonzero value on either channel restarts the count and releases this mute with that pair's output.
- R9: While clk_err_i is high, the sample pair that is scaled is the last pair accepted with clk_err_i low (zero if there has been none), not the current input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample-valid strobe |
| left_i | input | 32 | Left input sample, two's complement |
| right_i | input | 32 | Right input sample, two's complement |
| soft_mute_ni | input | 1 | Low requests mute, high requests un-mute |
| clk_err_i | input | 1 | Clock-error mute request; freezes the data source |
| valid_o | output | 1 | Output sample strobe |
| left_o | output | 32 | Attenuated left sample |
| right_o | output | 32 | Attenuated right sample |
| amute_o | output | 1 | Analog mute request |

## Verification
A reference model in the bench tracks the level, the zero run and the held pair, and predicts every output sample. The full ramps are driven with full-scale positive and negative values on opposite channels. At each of the 104 steps this tells apart a wrong gain code, a rounding error and a sign error. Several other patterns each isolate one behaviour:
- Short ramps that reverse part-way show whether the level is kept across a change of direction.
- Toggling the mute input between strobes, with valid_i low, shows whether the level changes without a strobe.
- A clock-error window with changing input data shows whether the held pair or the live data is being scaled.
- Runs of zeros of 1023 and 1024 pairs, broken by a single nonzero value on only one channel, pin down the detector's threshold and its release.

// File: rtl/smr_pkg.sv
package smr_pkg;
  localparam int unsigned GW       = 17;
  localparam int unsigned FRAC     = 16;
  localparam int unsigned UNITY    = 65536;
  localparam int unsigned STEP_MUL = 58409;  // 10^(-1/20) in Q16

  function automatic int unsigned gain_at(int unsigned k, int unsigned last);
    longint unsigned g;
    g = longint'(UNITY);
    if (k >= last) return 0;
    for (int unsigned i = 0; i < k; i++)
      g = (g * longint'(STEP_MUL) + 64'd32768) >> FRAC;
    return int'(g);
  endfunction
endpackage

// File: rtl/smr_gain_rom.sv
module smr_gain_rom
  import smr_pkg::*;
#(
  parameter int NSTEPS = 104,
  parameter int LW     = $clog2(NSTEPS + 1)
) (
  input  logic [LW-1:0] lvl_i,
  output logic [GW-1:0] gain_o
);
  logic [GW-1:0] tbl [NSTEPS+1];

  for (genvar k = 0; k <= NSTEPS; k++) begin : g_tbl
    localparam int unsigned GV = gain_at(k, NSTEPS);
    assign tbl[k] = GW'(GV);
  end

  always_comb begin
    if (int'(lvl_i) > NSTEPS) gain_o = '0;
    else                      gain_o = tbl[lvl_i];
  end
endmodule

// File: rtl/smr_scale.sv
module smr_scale
  import smr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] x_i,
  input  logic [GW-1:0] g_i,
  output logic [DW-1:0] y_o
);
  localparam int PW = DW + GW + 1;
  localparam logic signed [PW-1:0] MAXV = PW'(2 ** (DW - 1) - 1);
  localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC - 1);

  logic signed [PW-1:0] xs, gs, prod, rnd;

  always_comb begin
    xs   = PW'($signed(x_i));
    gs   = PW'($signed({1'b0, g_i}));
    prod = xs * gs;
    rnd  = (prod + HALF) >>> FRAC;
    if (rnd > MAXV)      y_o = MAXV[DW-1:0];
    else if (rnd < MINV) y_o = MINV[DW-1:0];
    else                 y_o = rnd[DW-1:0];
  end
endmodule

// File: rtl/smr_zero_det.sv
module smr_zero_det #(
  parameter int DW       = 32,
  parameter int ZERO_RUN = 1024,
  parameter int CW       = $clog2(ZERO_RUN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] left_i,
  input  logic [DW-1:0] right_i,
  output logic          hit_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (valid_i) begin
      if (left_i != '0 || right_i != '0) cnt_q <= '0;
      else if (cnt_q != CW'(ZERO_RUN))   cnt_q <= cnt_q + CW'(1);
    end
  end

  assign hit_o = (cnt_q == CW'(ZERO_RUN));
endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp
  import smr_pkg::*;
#(
  parameter int DW       = 32,
  parameter int NSTEPS   = 104,
  parameter int ZERO_RUN = 1024
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] left_i,
  input  logic [DW-1:0] right_i,
  input  logic          soft_mute_ni,
  input  logic          clk_err_i,
  output logic          valid_o,
  output logic [DW-1:0] left_o,
  output logic [DW-1:0] right_o,
  output logic          amute_o
);
  localparam int LW = $clog2(NSTEPS + 1);
  localparam logic [LW-1:0] LMAX = LW'(NSTEPS);

  logic [LW-1:0] lvl_q, lvl_d;
  logic          mute_req, zero_hit;
  logic [GW-1:0] gain;
  logic [DW-1:0] in_ch [2];
  logic [DW-1:0] hold_q [2];
  logic [DW-1:0] src [2];
  logic [DW-1:0] scl [2];
  logic [DW-1:0] out_q [2];

  assign mute_req = !soft_mute_ni || clk_err_i;
  assign in_ch[0] = left_i;
  assign in_ch[1] = right_i;

  always_comb begin
    lvl_d = lvl_q;
    if (valid_i) begin
      if (mute_req && lvl_q != LMAX)       lvl_d = lvl_q + LW'(1);
      else if (!mute_req && lvl_q != '0)   lvl_d = lvl_q - LW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q   <= '0;
      valid_o <= 1'b0;
    end else begin
      lvl_q   <= lvl_d;
      valid_o <= valid_i;
    end
  end

  smr_gain_rom #(.NSTEPS(NSTEPS), .LW(LW)) u_rom (
    .lvl_i (lvl_d),
    .gain_o(gain)
  );

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    // last good pair is replayed while a clock error is flagged
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     hold_q[ch] <= '0;
      else if (valid_i && !clk_err_i)  hold_q[ch] <= in_ch[ch];
    end

    assign src[ch] = clk_err_i ? hold_q[ch] : in_ch[ch];

    smr_scale #(.DW(DW)) u_scale (
      .x_i(src[ch]),
      .g_i(gain),
      .y_o(scl[ch])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      out_q[ch] <= '0;
      else if (valid_i) out_q[ch] <= scl[ch];
    end
  end

  smr_zero_det #(.DW(DW), .ZERO_RUN(ZERO_RUN)) u_zero (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .left_i (left_i),
    .right_i(right_i),
    .hit_o  (zero_hit)
  );

  assign left_o  = out_q[0];
  assign right_o = out_q[1];
  assign amute_o = (lvl_q == LMAX) || zero_hit;
endmodule

// File: rtl/soft_mute_ramp_chk.sv
module soft_mute_ramp_chk #(
  parameter int DW     = 32,
  parameter int NSTEPS = 104,
  parameter int LW     = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic          soft_mute_ni,
  input logic          clk_err_i,
  input logic          valid_o,
  input logic [DW-1:0] left_o,
  input logic [DW-1:0] right_o,
  input logic          amute_o,
  input logic [LW-1:0] lvl_q,
  input logic          zero_hit
);
  logic req;
  assign req = !soft_mute_ni || clk_err_i;

  assert_step_one_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (lvl_q == $past(lvl_q) || lvl_q == LW'($past(lvl_q) + LW'(1))
              || lvl_q == LW'($past(lvl_q) - LW'(1))));

  assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(lvl_q));

  assert_strobe_delay_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (valid_o == $past(valid_i)));

  assert_ramp_down_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && req && lvl_q != LW'(NSTEPS)) |=> (lvl_q == LW'($past(lvl_q) + LW'(1))));

  assert_ramp_up_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !req && lvl_q != '0) |=> (lvl_q == LW'($past(lvl_q) - LW'(1))));

  assert_silent_floor_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && lvl_q == LW'(NSTEPS)) |-> (left_o == '0 && right_o == '0));

  assert_two_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (amute_o && !zero_hit && valid_o) |-> (left_o == '0 && right_o == '0));
endmodule

bind soft_mute_ramp soft_mute_ramp_chk #(.DW(DW), .NSTEPS(NSTEPS), .LW(LW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .soft_mute_ni(soft_mute_ni),
  .clk_err_i   (clk_err_i),
  .valid_o     (valid_o),
  .left_o      (left_o),
  .right_o     (right_o),
  .amute_o     (amute_o),
  .lvl_q       (lvl_q),
  .zero_hit    (zero_hit)
);

// File: tb/soft_mute_ramp_tb.sv
module soft_mute_ramp_tb;
  localparam int N  = 104;
  localparam int ZR = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] left_i = '0, right_i = '0;
  logic        soft_mute_n = 1'b1;
  logic        clk_err = 1'b0;
  logic        valid_o, amute_o;
  logic [31:0] left_o, right_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  int          m_lvl = 0;
  int          m_zc = 0;
  logic [31:0] m_hl = '0, m_hr = '0;

  always #2.5 clk = ~clk;

  soft_mute_ramp u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .left_i(left_i), .right_i(right_i),
    .soft_mute_ni(soft_mute_n), .clk_err_i(clk_err),
    .valid_o(valid_o), .left_o(left_o), .right_o(right_o), .amute_o(amute_o)
  );

  function automatic longint gval(int k);
    longint g = 65536;
    if (k >= N) return 0;
    for (int i = 0; i < k; i++) g = (g * 58409 + 32768) >>> 16;
    return g;
  endfunction

  function automatic logic [31:0] scl(logic [31:0] x, int k);
    longint p, r;
    p = longint'($signed(x)) * gval(k);
    r = (p + 32768) >>> 16;
    if (r > 64'sd2147483647) r = 64'sd2147483647;
    if (r < -64'sd2147483648) r = -64'sd2147483648;
    return r[31:0];
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(logic [31:0] l, logic [31:0] r, string tag);
    logic [31:0] sl, sr, el, er;
    bit em;
    @(negedge clk);
    valid_i = 1'b1; left_i = l; right_i = r;
    if (!soft_mute_n || clk_err) begin if (m_lvl < N) m_lvl++; end
    else if (m_lvl > 0) m_lvl--;
    sl = clk_err ? m_hl : l;
    sr = clk_err ? m_hr : r;
    if (!clk_err) begin m_hl = l; m_hr = r; end
    if (l == 0 && r == 0) begin if (m_zc < ZR) m_zc++; end
    else m_zc = 0;
    el = scl(sl, m_lvl);
    er = scl(sr, m_lvl);
    em = (m_lvl == N) || (m_zc == ZR);
    @(negedge clk);
    valid_i = 1'b0;
    chk(valid_o == 1'b1, {tag, " valid_o"}, valid_o, 1);
    chk(left_o == el, {tag, " left"}, $signed(left_o), $signed(el));
    chk(right_o == er, {tag, " right"}, $signed(right_o), $signed(er));
    chk(amute_o == em, {tag, " amute"}, amute_o, em);
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(valid_o == 0, "R1 valid_o", valid_o, 0);
    chk(left_o == 0 && right_o == 0, "R1 data", left_o, 0);
    chk(amute_o == 0, "R1 amute", amute_o, 0);

    // R2 unity pass-through patterns
    send(32'h7FFF_FFFF, 32'h8000_0000, "R2 unity");
    send(32'hFFFF_FFFF, 32'h0000_0001, "R2 unity");
    send(32'h5555_5555, 32'hAAAA_AAAA, "R2 unity");
    send(32'h0000_0000, 32'h1234_5678, "R2 unity");

    // R3/R7 full ramp down with full-scale data
    soft_mute_n = 1'b0;
    for (int i = 0; i < N; i++)
      send((i % 2) ? 32'h8000_0000 : 32'h7FFF_FFFF,
           (i % 2) ? 32'h7FFF_FFFF : 32'h8000_0000, "R3 R7 down");
    chk(m_lvl == N, "R3 ramp length", m_lvl, N);
    send(32'h1234_5678, 32'h8765_4321, "R3 floor");

    // R6 mute toggled between strobes is ignored
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      soft_mute_n = ~soft_mute_n;
      chk(valid_o == 0, "R6 idle valid_o", valid_o, 0);
    end
    send(32'h4000_0000, 32'hC000_0000, "R6 idle level");

    // R4 full ramp up
    soft_mute_n = 1'b1;
    for (int i = 0; i < N; i++)
      send(32'h7FFF_FFFF - i, 32'h8000_0000 + i, "R4 up");
    chk(m_lvl == 0, "R4 ramp length", m_lvl, 0);

    // R5 reversal mid-ramp
    soft_mute_n = 1'b0;
    for (int i = 0; i < 10; i++) send(32'h0100_0000, 32'hFF00_0000, "R5 down");
    soft_mute_n = 1'b1;
    for (int i = 0; i < 3; i++) send(32'h0100_0000, 32'hFF00_0000, "R5 reverse");
    soft_mute_n = 1'b0;
    for (int i = 0; i < 2; i++) send(32'h0100_0000, 32'hFF00_0000, "R5 reverse again");
    soft_mute_n = 1'b1;
    for (int i = 0; i < 12; i++) send(32'h0300_0000, 32'hFD00_0000, "R5 settle");

    // R9 clock error replays last good pair
    send(32'h2222_2222, 32'hDDDD_DDDE, "R9 good");
    clk_err = 1'b1;
    for (int i = 0; i < 8; i++) send(32'h0F0F_0000 + i, 32'h7000_0000 - i, "R9 held");
    clk_err = 1'b0;
    for (int i = 0; i < 10; i++) send(32'h0F0F_0000 + i, 32'h7000_0000 - i, "R9 fresh");

    // R8 zero run threshold and release
    for (int i = 0; i < 500; i++) send('0, '0, "R8 run");
    send('0, 32'h0000_0001, "R8 break");
    for (int i = 0; i < ZR - 1; i++) send('0, '0, "R8 below");
    send('0, '0, "R8 threshold");
    send('0, '0, "R8 held");
    send(32'hFFFF_FFFF, '0, "R8 release");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule